// File: doc/BRIEF.md
# ADC Channel Scan Sequencer

This block drives the channel-select lines of a 64-way analog multiplexer and the start strobe of an external converter. It is programmed through a small register port. Software sets a scan window, which is a first and a last channel. Each accepted conversion trigger starts one conversion on the current channel and moves the scan position forward. After the last channel it goes back to the first. A trigger can come from a register write, from either edge of an external trigger pin, or from a pacer tick. Only one of these is active at a time.

Each finished result goes into an internal sample queue. The queue is read through the data register, which returns the result left-justified. A status register shows the fill state of the queue and the event flags. An interrupt fires on a queue-driven condition chosen by software. Each flag is cleared by writing a one to its bit in the status register.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset the scan window is channel 0 to 0, the trigger source is software, the interrupt mode is polled, differential input is selected, and every status bit and the irq output are 0. Register addresses are: data 0, window 1, control 2, mode 3, status 4.
- R2: The window register (address 1) holds the first channel in bits [5:0] and the last channel in bits [13:8], and reads back as written. Writing it restarts the scan at the first channel. Equal fields select one fixed channel.
- R3: Each started conversion uses the current scan channel. The next one uses that channel plus one, or the first channel if the current channel equals the last.
- R4: Control bits [1:0] select the trigger source: 0 software, 1 external falling edge, 2 external rising edge, 3 pacer tick. With source 0, a write to the data register (address 0) pulses conv_start for one cycle, in the cycle after the write. With any other source, data-register writes start nothing.
- R5: With source 1 or 2, an edge of the selected direction on ext_trig_in starts a conversion and sets status bit 5. An edge of the other direction does nothing. With source 3, a pacer_tick pulse starts a conversion.
- R6: A trigger that arrives after conv_start and before conv_done is ignored.
- R7: Status bit 0 is queue not empty, bit 1 is queue holding at least half its depth (4 of 8 by default), and bit 2 is queue full.
- R8: A result that arrives while the queue is full is discarded. The full flag stays set until a data read removes an entry.
- R9: Reading the data register returns the oldest result in bits [15:4] with bits [3:0] zero, and removes that result from the queue.
- R10: Mode bits [3:2] select when the interrupt becomes pending. 0 means never. 1 means on every arriving result. 2 means on a result that brings the queue to at least half depth. 3 means on a result from a conversion of the last channel in the window.
- R11: Status bit 4 shows the pending interrupt. The irq output is pending AND control bit 7.
- R12: A status write with bit 0 set clears the pending interrupt. Bit 1 clears status bit 5. Bit 2 clears status bit 3, which is set by a rising edge on ext_irq_in.
- R13: When mode bit 5 (single-ended) is 0, conv_chan is forced into the range 0 to 31 by clearing its bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the queue at the data address) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| ext_trig_in | input | 1 | External conversion trigger pin |
| ext_irq_in | input | 1 | External interrupt request pin |
| pacer_tick | input | 1 | One-cycle pacer pulse |
| conv_start | output | 1 | One-cycle conversion start strobe |
| conv_chan | output | 6 | Multiplexer channel for the conversion |
| conv_done | input | 1 | Converter result valid strobe |
| conv_result | input | 12 | Converter result |
| irq | output | 1 | Interrupt request |

## Verification
The bench covers the wrap of the scan window at its last channel, including a window at the top of the 64-channel range. A design that wraps to zero instead of to the first channel, or that runs past the last channel, shows the wrong conv_chan there. It also fills the queue past full and checks that the oldest entry survives and the newest is dropped; a design that overwrites data returns a different first word. Each interrupt mode, the enable gate, both external edge directions, a trigger arriving during a conversion, and differential channel folding are each driven in isolation. A design that mixes up an encoding or a polarity raises irq or conv_start in a cycle where the bench expects it low.

// File: rtl/adc_scan_pkg.sv
// Shared encodings for the scan sequencer: register addresses, trigger
// sources, interrupt modes and status bit positions.
package adc_scan_pkg;
    typedef enum logic [1:0] {
        TRG_SOFT  = 2'd0,
        TRG_FALL  = 2'd1,
        TRG_RISE  = 2'd2,
        TRG_PACER = 2'd3
    } trig_src_e;

    typedef enum logic [1:0] {
        IRQ_POLL     = 2'd0,
        IRQ_NONEMPTY = 2'd1,
        IRQ_HALF     = 2'd2,
        IRQ_BURST    = 2'd3
    } irq_mode_e;

    localparam logic [2:0] A_DATA = 3'd0;
    localparam logic [2:0] A_WIN  = 3'd1;
    localparam logic [2:0] A_CTRL = 3'd2;
    localparam logic [2:0] A_MODE = 3'd3;
    localparam logic [2:0] A_STAT = 3'd4;

    localparam int ST_NEMPTY = 0;
    localparam int ST_HALF   = 1;
    localparam int ST_FULL   = 2;
    localparam int ST_XIRQ   = 3;
    localparam int ST_PEND   = 4;
    localparam int ST_XTRIG  = 5;

    localparam int HI_LSB    = 8;
    localparam int CTRL_IEN  = 7;
    localparam int MODE_SE   = 5;
endpackage

// File: rtl/scan_trig_unit.sv
// Trigger selector. Registers the external pin once to find its edges,
// then forwards the event of the selected source as a one-cycle request.
// Assumes ext_in is already synchronous to clk.
module scan_trig_unit
    import adc_scan_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  trig_src_e src,
    input  logic      soft_wr,
    input  logic      ext_in,
    input  logic      pacer_tick,
    output logic      trig_req,
    output logic      ext_hit
);
    logic ext_q;
    logic fall_ev;
    logic rise_ev;

    // Previous pin level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_q <= 1'b0;
        else        ext_q <= ext_in;
    end

    assign fall_ev = ext_q & ~ext_in;
    assign rise_ev = ~ext_q & ext_in;

    // Select the active trigger source.
    always_comb begin
        case (src)
            TRG_SOFT:  trig_req = soft_wr;
            TRG_FALL:  trig_req = fall_ev;
            TRG_RISE:  trig_req = rise_ev;
            TRG_PACER: trig_req = pacer_tick;
        endcase
    end

    assign ext_hit = ((src == TRG_FALL) & fall_ev) | ((src == TRG_RISE) & rise_ev);
endmodule

// File: rtl/scan_chan_ctr.sv
// Scan position counter. A load puts it at the first channel; each step
// moves it up by one, and from the last channel back to the first.
// Assumes first <= last for a meaningful window; otherwise it counts
// modulo 2**CW until it meets the last channel.
module scan_chan_ctr #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_lo,
    input  logic          step,
    input  logic [CW-1:0] lo,
    input  logic [CW-1:0] hi,
    output logic [CW-1:0] cur
);
    // Advance or restart the scan position.
    always_ff @(posedge clk) begin
        if (!rst_n)    cur <= '0;
        else if (load) cur <= load_lo;
        else if (step) cur <= (cur == hi) ? lo : cur + 1'b1;
    end
endmodule

// File: rtl/scan_sample_fifo.sv
// Result queue with occupancy count. A push into a full queue is dropped;
// a pop from an empty queue is ignored. DEPTH must be a power of two.
module scan_sample_fifo #(
    parameter int W     = 12,
    parameter int DEPTH = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int CNT_W = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     dout,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp;
    logic [AW-1:0] rp;
    logic          wr_ok;
    logic          rd_ok;

    assign full  = (count == CNT_MAX);
    assign empty = (count == '0);
    assign wr_ok = push & ~full;
    assign rd_ok = pop & ~empty;
    assign dout  = mem[rp];

    // Storage write.
    always_ff @(posedge clk) begin
        if (wr_ok) mem[wp] <= din;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (wr_ok) wp <= wp + 1'b1;
            if (rd_ok) rp <= rp + 1'b1;
            case ({wr_ok, rd_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/adc_scan_seq.sv
// Scan sequencer top: register port, conversion start control, result
// queue and interrupt logic. Assumes the converter answers each
// conv_start with one conv_done and never asserts conv_done unprompted.
module adc_scan_seq
    import adc_scan_pkg::*;
#(
    parameter int CW         = 6,
    parameter int RES_W      = 12,
    parameter int DATA_W     = 16,
    parameter int FIFO_DEPTH = 8,
    localparam int CNT_W     = $clog2(FIFO_DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ext_trig_in,
    input  logic              ext_irq_in,
    input  logic              pacer_tick,
    output logic              conv_start,
    output logic [CW-1:0]     conv_chan,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_result,
    output logic              irq
);
    localparam logic [CNT_W-1:0] HALF_M1 = CNT_W'(FIFO_DEPTH / 2 - 1);

    logic [CW-1:0]    mux_lo, mux_hi, cur_chan, flight_chan;
    trig_src_e        trig_src;
    irq_mode_e        irq_mode;
    logic             irq_en_q, se_q, busy_q;
    logic             irq_pend, xtrig_flag, xirq_flag, xirq_q;
    logic             wr_data, wr_win, wr_ctrl, wr_mode, wr_stat, pop_data;
    logic             trig_req, ext_hit, start_now, pend_set;
    logic [RES_W-1:0] fifo_dout;
    logic [CNT_W-1:0] fifo_count;
    logic             fifo_full, fifo_empty;
    logic             unused_wbits;

    assign wr_data  = bus_wr & (bus_addr == A_DATA);
    assign wr_win   = bus_wr & (bus_addr == A_WIN);
    assign wr_ctrl  = bus_wr & (bus_addr == A_CTRL);
    assign wr_mode  = bus_wr & (bus_addr == A_MODE);
    assign wr_stat  = bus_wr & (bus_addr == A_STAT);
    assign pop_data = bus_rd & (bus_addr == A_DATA);
    assign unused_wbits = ^{bus_wdata[DATA_W-1:HI_LSB+CW], bus_wdata[6]};

    scan_trig_unit u_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .src        (trig_src),
        .soft_wr    (wr_data),
        .ext_in     (ext_trig_in),
        .pacer_tick (pacer_tick),
        .trig_req   (trig_req),
        .ext_hit    (ext_hit)
    );

    assign start_now = trig_req & ~busy_q;

    scan_chan_ctr #(.CW(CW)) u_chan (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (wr_win),
        .load_lo (bus_wdata[CW-1:0]),
        .step    (start_now),
        .lo      (mux_lo),
        .hi      (mux_hi),
        .cur     (cur_chan)
    );

    scan_sample_fifo #(.W(RES_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (conv_done),
        .din   (conv_result),
        .pop   (pop_data),
        .dout  (fifo_dout),
        .count (fifo_count),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    // Configuration registers written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mux_lo   <= '0;
            mux_hi   <= '0;
            trig_src <= TRG_SOFT;
            irq_en_q <= 1'b0;
            irq_mode <= IRQ_POLL;
            se_q     <= 1'b0;
        end else begin
            if (wr_win) begin
                mux_lo <= bus_wdata[CW-1:0];
                mux_hi <= bus_wdata[HI_LSB +: CW];
            end
            if (wr_ctrl) begin
                trig_src <= trig_src_e'(bus_wdata[1:0]);
                irq_en_q <= bus_wdata[CTRL_IEN];
            end
            if (wr_mode) begin
                irq_mode <= irq_mode_e'(bus_wdata[3:2]);
                se_q     <= bus_wdata[MODE_SE];
            end
        end
    end

    // Conversion start strobe, channel capture and busy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_start  <= 1'b0;
            conv_chan   <= '0;
            flight_chan <= '0;
            busy_q      <= 1'b0;
        end else begin
            conv_start <= start_now;
            if (start_now) begin
                conv_chan   <= se_q ? cur_chan : {1'b0, cur_chan[CW-2:0]};
                flight_chan <= cur_chan;
                busy_q      <= 1'b1;
            end else if (conv_done) begin
                busy_q <= 1'b0;
            end
        end
    end

    // Interrupt pending condition for the selected mode.
    always_comb begin
        case (irq_mode)
            IRQ_POLL:     pend_set = 1'b0;
            IRQ_NONEMPTY: pend_set = conv_done;
            IRQ_HALF:     pend_set = conv_done & (fifo_count >= HALF_M1);
            IRQ_BURST:    pend_set = conv_done & (flight_chan == mux_hi);
        endcase
    end

    // Sticky event flags with write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_pend   <= 1'b0;
            xtrig_flag <= 1'b0;
            xirq_flag  <= 1'b0;
            xirq_q     <= 1'b0;
        end else begin
            xirq_q <= ext_irq_in;
            if (wr_stat && bus_wdata[0]) irq_pend <= 1'b0;
            else if (pend_set)           irq_pend <= 1'b1;
            if (wr_stat && bus_wdata[1]) xtrig_flag <= 1'b0;
            else if (ext_hit)            xtrig_flag <= 1'b1;
            if (wr_stat && bus_wdata[2]) xirq_flag <= 1'b0;
            else if (ext_irq_in && !xirq_q) xirq_flag <= 1'b1;
        end
    end

    assign irq = irq_pend & irq_en_q;

    // Read data selection.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_DATA: if (!fifo_empty) bus_rdata[DATA_W-1 -: RES_W] = fifo_dout;
            A_WIN: begin
                bus_rdata[CW-1:0]       = mux_lo;
                bus_rdata[HI_LSB +: CW] = mux_hi;
            end
            A_CTRL: begin
                bus_rdata[1:0]      = trig_src;
                bus_rdata[CTRL_IEN] = irq_en_q;
            end
            A_MODE: begin
                bus_rdata[3:2]     = irq_mode;
                bus_rdata[MODE_SE] = se_q;
            end
            A_STAT: begin
                bus_rdata[ST_NEMPTY] = ~fifo_empty;
                bus_rdata[ST_HALF]   = (fifo_count > HALF_M1);
                bus_rdata[ST_FULL]   = fifo_full;
                bus_rdata[ST_XIRQ]   = xirq_flag;
                bus_rdata[ST_PEND]   = irq_pend;
                bus_rdata[ST_XTRIG]  = xtrig_flag;
            end
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/adc_scan_seq_chk.sv
// Property checker for the scan sequencer, attached by bind.
module adc_scan_seq_chk #(
    parameter int CW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          conv_start,
    input logic [CW-1:0] conv_chan,
    input logic          conv_done,
    input logic          irq,
    input logic          busy_q,
    input logic          irq_pend,
    input logic          irq_en_q,
    input logic          se_q,
    input logic [CW-1:0] mux_lo,
    input logic [CW-1:0] mux_hi,
    input logic          fifo_full,
    input logic          pop_data
);
    p_one_cycle_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    p_no_start_in_flight_r6: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> !$past(busy_q));

    p_chan_in_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && $past(se_q) && ($past(mux_lo) <= $past(mux_hi)))
        |-> (conv_chan >= $past(mux_lo)) && (conv_chan <= $past(mux_hi)));

    p_diff_low_half_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && !$past(se_q)) |-> !conv_chan[CW-1]);

    p_pend_from_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_pend) |-> $past(conv_done));

    p_irq_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en_q |-> !irq);

    p_full_sticks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && !pop_data) |=> fifo_full);
endmodule

bind adc_scan_seq adc_scan_seq_chk #(.CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_start (conv_start),
    .conv_chan  (conv_chan),
    .conv_done  (conv_done),
    .irq        (irq),
    .busy_q     (busy_q),
    .irq_pend   (irq_pend),
    .irq_en_q   (irq_en_q),
    .se_q       (se_q),
    .mux_lo     (mux_lo),
    .mux_hi     (mux_hi),
    .fifo_full  (fifo_full),
    .pop_data   (pop_data)
);

// File: tb/test_adc_scan_seq.sv
module test_adc_scan_seq;
    import adc_scan_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        ext_trig_in = 1'b0, ext_irq_in = 1'b0, pacer_tick = 1'b0;
    logic        conv_start, conv_done = 1'b0, irq;
    logic [5:0]  conv_chan;
    logic [11:0] conv_result = '0;
    int          n_cmp = 0, n_bad = 0;
    bit          finished = 1'b0;

    always #10 clk = ~clk;

    adc_scan_seq i_adc_scan_seq (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_trig_in(ext_trig_in), .ext_irq_in(ext_irq_in),
        .pacer_tick(pacer_tick), .conv_start(conv_start),
        .conv_chan(conv_chan), .conv_done(conv_done),
        .conv_result(conv_result), .irq(irq)
    );

    // {se, first, last, five expected channels}
    localparam logic [42:0] VEC [0:4] = '{
        {1'b1, 6'd3,  6'd5,  6'd3,  6'd4,  6'd5,  6'd3,  6'd4},
        {1'b1, 6'd7,  6'd7,  6'd7,  6'd7,  6'd7,  6'd7,  6'd7},
        {1'b1, 6'd40, 6'd42, 6'd40, 6'd41, 6'd42, 6'd40, 6'd41},
        {1'b0, 6'd40, 6'd42, 6'd8,  6'd9,  6'd10, 6'd8,  6'd9},
        {1'b1, 6'd62, 6'd63, 6'd62, 6'd63, 6'd62, 6'd63, 6'd62}
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic finish_conv(input logic [11:0] r);
        conv_done = 1'b1; conv_result = r;
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    // Soft-triggered conversion; checks start strobe and channel.
    task automatic soft_conv(input string tag, input logic [5:0] ch, input logic [11:0] r);
        bus_write(A_DATA, 16'h0000);
        check({tag, " start"}, {15'd0, conv_start}, 16'd1);
        check({tag, " chan"}, {10'd0, conv_chan}, {10'd0, ch});
        finish_conv(r);
    endtask

    task automatic drain(input int n);
        logic [15:0] d;
        for (int i = 0; i < n; i++) bus_read(A_DATA, d);
    endtask

    initial begin
        logic [15:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(A_WIN, d);  check("R1 window", d, 16'h0000);
        bus_read(A_CTRL, d); check("R1 control", d, 16'h0000);
        bus_read(A_MODE, d); check("R1 mode", d, 16'h0000);
        bus_read(A_STAT, d); check("R1 status", d, 16'h0000);
        check("R1 irq", {15'd0, irq}, 16'd0);

        // R2 R3 R9 R13: vector table of scan windows
        for (int v = 0; v < 5; v++) begin
            automatic logic [42:0] e = VEC[v];
            bus_write(A_MODE, e[42] ? 16'h0020 : 16'h0000);
            bus_write(A_WIN, {2'b00, e[35:30], 2'b00, e[41:36]});
            bus_read(A_WIN, d);
            check("R2 window readback", d, {2'b00, e[35:30], 2'b00, e[41:36]});
            for (int k = 0; k < 5; k++)
                soft_conv("R3 R13 scan", e[29-6*k -: 6], {6'h2A, e[29-6*k -: 6]});
            for (int k = 0; k < 5; k++) begin
                bus_read(A_DATA, d);
                check("R9 data word", d, {6'h2A, e[29-6*k -: 6], 4'h0});
            end
            bus_read(A_STAT, d); check("R7 empty after drain", d, 16'h0000);
        end

        // R2 rewriting the window restarts the scan
        bus_write(A_MODE, 16'h0020);
        bus_write(A_WIN, 16'h0C0A);
        soft_conv("R2 first", 6'd10, 12'h001);
        soft_conv("R2 second", 6'd11, 12'h002);
        bus_write(A_WIN, 16'h0C0A);
        soft_conv("R2 restart", 6'd10, 12'h003);
        drain(3);

        // R7 R8 fill levels and overflow
        bus_write(A_WIN, 16'h0101);
        for (int i = 0; i < 9; i++) begin
            soft_conv("R8 fill", 6'd1, 12'h100 + 12'(i));
            bus_read(A_STAT, d);
            if (i == 2) check("R7 below half", d, 16'h0001);
            if (i == 3) check("R7 half", d, 16'h0003);
            if (i == 7) check("R7 full", d, 16'h0007);
            if (i == 8) check("R8 full persists", d, 16'h0007);
        end
        bus_read(A_DATA, d); check("R8 oldest kept", d, 16'h1000);
        bus_read(A_STAT, d); check("R8 full cleared by read", d, 16'h0003);
        for (int i = 1; i < 8; i++) begin
            bus_read(A_DATA, d);
            if (i == 7) check("R8 newest dropped", d, 16'h1070);
        end
        bus_read(A_STAT, d); check("R8 empty", d, 16'h0000);

        // R10 R11 R12 interrupt modes
        bus_write(A_CTRL, 16'h0080);
        bus_write(A_MODE, 16'h0024);
        soft_conv("R10 mode1", 6'd1, 12'h011);
        check("R11 irq mode1", {15'd0, irq}, 16'd1);
        bus_read(A_STAT, d); check("R11 pend bit", d, 16'h0011);
        bus_write(A_STAT, 16'h0001);
        check("R12 irq cleared", {15'd0, irq}, 16'd0);
        drain(1);
        bus_write(A_CTRL, 16'h0000);
        soft_conv("R11 gated", 6'd1, 12'h012);
        check("R11 irq gated off", {15'd0, irq}, 16'd0);
        bus_read(A_STAT, d); check("R11 pend visible", d, 16'h0011);
        bus_write(A_STAT, 16'h0001); drain(1);
        bus_write(A_CTRL, 16'h0080);
        bus_write(A_MODE, 16'h0020);
        soft_conv("R10 polled", 6'd1, 12'h013);
        bus_read(A_STAT, d); check("R10 polled no pend", d, 16'h0001);
        drain(1);
        bus_write(A_MODE, 16'h0028);
        for (int i = 0; i < 4; i++) begin
            soft_conv("R10 half", 6'd1, 12'h020);
            if (i == 2) check("R10 half not yet", {15'd0, irq}, 16'd0);
            if (i == 3) check("R10 half reached", {15'd0, irq}, 16'd1);
        end
        bus_write(A_STAT, 16'h0001); drain(4);
        bus_write(A_MODE, 16'h002C);
        bus_write(A_WIN, 16'h0402);
        soft_conv("R10 burst", 6'd2, 12'h030);
        soft_conv("R10 burst", 6'd3, 12'h031);
        check("R10 burst mid", {15'd0, irq}, 16'd0);
        soft_conv("R10 burst", 6'd4, 12'h032);
        check("R10 burst end", {15'd0, irq}, 16'd1);
        bus_write(A_STAT, 16'h0001); drain(3);
        bus_write(A_MODE, 16'h0020);
        bus_write(A_CTRL, 16'h0000);
        bus_write(A_WIN, 16'h0505);

        // R6 trigger during a conversion
        bus_write(A_DATA, 16'h0000);
        check("R6 first start", {15'd0, conv_start}, 16'd1);
        bus_write(A_DATA, 16'h0000);
        check("R6 ignored start", {15'd0, conv_start}, 16'd0);
        finish_conv(12'h040);
        bus_read(A_STAT, d); check("R6 one sample", d, 16'h0001);
        drain(1);

        // R4 R5 external falling edge
        bus_write(A_CTRL, 16'h0001);
        bus_write(A_DATA, 16'h0000);
        check("R4 soft ignored ext", {15'd0, conv_start}, 16'd0);
        ext_trig_in = 1'b1;
        @(negedge clk);
        check("R5 wrong edge", {15'd0, conv_start}, 16'd0);
        ext_trig_in = 1'b0;
        @(negedge clk);
        check("R5 falling start", {15'd0, conv_start}, 16'd1);
        finish_conv(12'h050);
        bus_read(A_STAT, d); check("R5 ext flag", d, 16'h0021);
        bus_write(A_STAT, 16'h0002);
        bus_read(A_STAT, d); check("R12 ext flag cleared", d, 16'h0001);
        drain(1);

        // R5 external rising edge
        bus_write(A_CTRL, 16'h0002);
        ext_trig_in = 1'b1;
        @(negedge clk);
        check("R5 rising start", {15'd0, conv_start}, 16'd1);
        finish_conv(12'h051);
        ext_trig_in = 1'b0;
        @(negedge clk);
        check("R5 rising ignores fall", {15'd0, conv_start}, 16'd0);
        bus_write(A_STAT, 16'h0002); drain(1);

        // R5 pacer
        bus_write(A_CTRL, 16'h0003);
        bus_write(A_DATA, 16'h0000);
        check("R4 soft ignored pacer", {15'd0, conv_start}, 16'd0);
        pacer_tick = 1'b1;
        @(negedge clk);
        pacer_tick = 1'b0;
        check("R5 pacer start", {15'd0, conv_start}, 16'd1);
        finish_conv(12'h060);
        bus_read(A_DATA, d); check("R5 pacer data", d, 16'h0600);

        // R12 external interrupt flag
        ext_irq_in = 1'b1;
        @(negedge clk);
        bus_read(A_STAT, d); check("R12 xirq set", d, 16'h0008);
        bus_write(A_STAT, 16'h0004);
        bus_read(A_STAT, d); check("R12 xirq cleared", d, 16'h0000);
        ext_irq_in = 1'b0;

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule